// File: doc/BRIEF.md
# Packet Bit-Stream Monitor Streamer

This block copies every packet that a radio sends or receives onto a three-wire synchronous debug port, so that an external logic analyser or capture board can follow all link traffic. The three wires are a generated bit clock (`mon_clk`), a serial data line (`mon_data`) and a frame line (`mon_frame`). The bit clock is the system clock divided by `CLK_DIV`. With a 4 MHz system clock and the default divider of 16, this gives the 250 kHz link bit rate. Both data and frame change only on the falling edge of the bit clock, so they are stable when an observer samples them on the rising edge.

Packet bytes enter through a valid/ready port. The first byte carries a start flag and the direction (transmit or receive). The final byte carries a last flag. The frame line rises for one marker bit before the payload, and during that bit the data line shows the direction. The frame line then stays high while the payload bits go out, least significant bit first. It drops after the final bit. A minimum quiet gap with the frame line low is enforced before the next packet may start.

The controller is a four-state machine:

- `ST_IDLE`: waiting for a start byte.
- `ST_MARK`: the marker bit is on the wire.
- `ST_DATA`: payload bits are on the wire.
- `ST_GAP`: the quiet gap is being counted.

Its transitions are:

- `ST_IDLE`→`ST_MARK`: a start byte is accepted.
- `ST_MARK`→`ST_DATA`: the next falling edge arrives.
- `ST_DATA`→`ST_DATA`: a byte is refilled at its final bit.
- `ST_DATA`→`ST_GAP`: the last byte ends, or no byte is offered when one is needed.
- `ST_GAP`→`ST_IDLE`: the gap count is reached.

Top module: `pkt_mon_streamer`

## Requirements
- R1: `mon_clk` is periodic with a period of `CLK_DIV` system clocks. It is high for `CLK_DIV/2` cycles and low for `CLK_DIV/2` cycles, and it is low after reset.
- R2: `mon_data` and `mon_frame` change only at the system clock edge where `mon_clk` goes from 1 to 0.
- R3: A packet starts with one marker bit period in which `mon_frame` is 1. In that bit `mon_data` is 1 for a transmit packet (`in_tx`=1 on the start byte) and 0 for a receive packet.
- R4: After the marker, each byte goes out as `BYTE_W` bit periods, bit 0 first, with bytes in acceptance order and `mon_frame` held at 1.
- R5: On the falling edge that ends the final bit of the byte flagged with `in_last`, `mon_frame` and `mon_data` both go to 0.
- R6: Between packets `mon_frame` stays 0 for at least `IDLE_BITS` bit periods. When the next start byte is already waiting, the gap is exactly `IDLE_BITS` bit periods.
- R7: `in_ready` is high only for a single system cycle, and that cycle is the last one before a falling edge of `mon_clk`. It is offered only in `ST_IDLE`, or in `ST_DATA` while the final bit of a byte that is not the last one is showing.
- R8: A byte accepted in `ST_IDLE` with `in_first`=0 is discarded, and `mon_frame` stays 0.
- R9: If `in_valid` is 0 when `in_ready` is offered in `ST_DATA`, the packet ends exactly as in R5 (underrun).
- R10: During reset and right after it, `mon_clk`, `mon_data`, `mon_frame` and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | BYTE_W | Packet byte |
| in_first | input | 1 | Byte is the first of a packet |
| in_tx | input | 1 | Direction, sampled with the first byte (1 = transmit) |
| in_last | input | 1 | Byte is the final one of the packet |
| in_ready | output | 1 | Byte is taken at this clock edge when in_valid is 1 |
| mon_clk | output | 1 | Generated bit clock |
| mon_data | output | 1 | Serial data line |
| mon_frame | output | 1 | Frame line |

## Verification
The situation hardest to reach from the ports is the exact-length quiet gap. It only appears when the next start byte is already pending while the previous packet drains, so the stimulus queues packets back to back with no pause between the final handshake of one and the start byte of the next. The refill at a byte boundary is similarly narrow, since `in_ready` is open for one system cycle per byte. For that reason the driver holds each byte valid well before the pulse. Underrun is reached by withholding the second byte of a packet. The discard case is reached by offering a byte without the start flag while idle.

// File: rtl/pkt_mon_pkg.sv
package pkt_mon_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MARK = 2'd1,
        ST_DATA = 2'd2,
        ST_GAP  = 2'd3
    } mon_state_e;
endpackage

// File: rtl/pkt_mon_clkgen.sv
module pkt_mon_clkgen #(
    parameter int CLK_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic bit_clk,
    output logic fall_tick
);
    localparam int CW   = $clog2(CLK_DIV);
    localparam int HALF = CLK_DIV / 2;

    logic [CW-1:0] cnt_q;
    logic          clk_q;

    assign fall_tick = (cnt_q == CW'(CLK_DIV - 1));
    assign bit_clk   = clk_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else begin
            cnt_q <= fall_tick ? '0 : cnt_q + 1'b1;
            if (cnt_q == CW'(HALF - 1))
                clk_q <= 1'b1;
            else if (fall_tick)
                clk_q <= 1'b0;
        end
    end

    // checker: length of each high phase
    logic [CW:0] hi_len;
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_len <= '0;
        else if (clk_q) hi_len <= hi_len + 1'b1;
        else            hi_len <= '0;
    end

    assert_high_phase_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_q) |-> hi_len == (CW+1)'(HALF));
endmodule

// File: rtl/pkt_mon_shifter.sv
module pkt_mon_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              load_full,
    input  logic              load_shift,
    input  logic              shift,
    output logic              cur_bit,
    output logic              drained
);
    localparam int BW = $clog2(BYTE_W + 1);

    logic [BYTE_W-1:0] sh_q;
    logic [BW-1:0]     sent_q;

    assign cur_bit = sh_q[0];
    assign drained = (sent_q == BW'(BYTE_W));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            sent_q <= '0;
        end else if (load_full) begin
            sh_q   <= byte_in;
            sent_q <= '0;
        end else if (load_shift) begin
            sh_q   <= byte_in >> 1;
            sent_q <= BW'(1);
        end else if (shift) begin
            sh_q   <= sh_q >> 1;
            sent_q <= sent_q + 1'b1;
        end
    end

    assert_no_overrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift |-> !drained);
endmodule

// File: rtl/pkt_mon_ctrl.sv
module pkt_mon_ctrl #(
    parameter int IDLE_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic in_valid,
    input  logic in_first,
    input  logic in_tx,
    input  logic in_last,
    input  logic in_bit0,
    output logic in_ready,
    input  logic drained,
    input  logic cur_bit,
    output logic load_full,
    output logic load_shift,
    output logic shift,
    output logic frame_o,
    output logic data_o
);
    import pkt_mon_pkg::*;

    localparam int GW = $clog2(IDLE_BITS + 1);

    mon_state_e st_q, st_d;
    logic          frame_q, data_q, last_q;
    logic [GW-1:0] gap_q;
    logic          accept, end_pkt;

    assign in_ready   = tick && ((st_q == ST_IDLE) ||
                                 (st_q == ST_DATA && drained && !last_q));
    assign accept     = in_valid && in_ready;
    assign load_full  = accept && (st_q == ST_IDLE) && in_first;
    assign load_shift = accept && (st_q == ST_DATA);
    assign shift      = tick && ((st_q == ST_MARK) ||
                                 (st_q == ST_DATA && !drained));
    assign end_pkt    = tick && (st_q == ST_DATA) && drained &&
                        (last_q || !in_valid);
    assign frame_o    = frame_q;
    assign data_o     = data_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (load_full) st_d = ST_MARK;
            ST_MARK: if (tick) st_d = ST_DATA;
            ST_DATA: if (end_pkt) st_d = ST_GAP;
            ST_GAP:  if (tick && gap_q == GW'(IDLE_BITS - 2)) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs and packet context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= 1'b0;
            data_q  <= 1'b0;
            last_q  <= 1'b0;
            gap_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (load_full) begin
                    frame_q <= 1'b1;
                    data_q  <= in_tx;
                    last_q  <= in_last;
                end
                ST_MARK: if (tick) data_q <= cur_bit;
                ST_DATA: if (tick) begin
                    if (!drained) begin
                        data_q <= cur_bit;
                    end else if (end_pkt) begin
                        frame_q <= 1'b0;
                        data_q  <= 1'b0;
                        gap_q   <= '0;
                    end else begin
                        data_q <= in_bit0;
                        last_q <= in_last;
                    end
                end
                ST_GAP: if (tick) gap_q <= gap_q + 1'b1;
                default: ;
            endcase
        end
    end

    // checker: bit periods spent with frame low
    logic [GW-1:0] low_bits;
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_bits <= GW'(IDLE_BITS);
        else if (tick) begin
            if (frame_q)
                low_bits <= '0;
            else if (low_bits != GW'(IDLE_BITS))
                low_bits <= low_bits + 1'b1;
        end
    end

    assert_min_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_q) |-> low_bits == GW'(IDLE_BITS));
    assert_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && accept && !in_first) |=> !frame_q);
    assert_end_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && tick && drained && last_q) |=> (!frame_q && !data_q));
    assert_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DATA && in_ready && !in_valid) |=> !frame_q);
endmodule

// File: rtl/pkt_mon_streamer.sv
module pkt_mon_streamer #(
    parameter int CLK_DIV   = 16,
    parameter int BYTE_W    = 8,
    parameter int IDLE_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_tx,
    input  logic              in_last,
    output logic              in_ready,
    output logic              mon_clk,
    output logic              mon_data,
    output logic              mon_frame
);
    logic tick, load_full, load_shift, shift, cur_bit, drained;

    pkt_mon_clkgen #(.CLK_DIV(CLK_DIV)) clkgen_i (
        .clk(clk), .rst_n(rst_n), .bit_clk(mon_clk), .fall_tick(tick)
    );

    pkt_mon_shifter #(.BYTE_W(BYTE_W)) shifter_i (
        .clk(clk), .rst_n(rst_n), .byte_in(in_data),
        .load_full(load_full), .load_shift(load_shift), .shift(shift),
        .cur_bit(cur_bit), .drained(drained)
    );

    pkt_mon_ctrl #(.IDLE_BITS(IDLE_BITS)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .in_valid(in_valid), .in_first(in_first), .in_tx(in_tx),
        .in_last(in_last), .in_bit0(in_data[0]), .in_ready(in_ready),
        .drained(drained), .cur_bit(cur_bit),
        .load_full(load_full), .load_shift(load_shift), .shift(shift),
        .frame_o(mon_frame), .data_o(mon_data)
    );

    assert_frame_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mon_frame) |-> $fell(mon_clk));
    assert_data_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mon_data) |-> $fell(mon_clk));
    assert_marker_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mon_frame) |-> mon_data == $past(in_tx));
    assert_ready_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> ($fell(mon_clk) && !in_ready));
endmodule

// File: tb/pkt_mon_streamer_tb_top.sv
module pkt_mon_streamer_tb_top;
    localparam int DIV = 16;
    localparam int IDB = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 1'b0, in_first = 1'b0, in_tx = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, mon_clk, mon_data, mon_frame;

    always #5 clk = ~clk;

    pkt_mon_streamer #(.CLK_DIV(DIV), .BYTE_W(8), .IDLE_BITS(IDB)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_first(in_first), .in_tx(in_tx), .in_last(in_last),
        .in_ready(in_ready), .mon_clk(mon_clk), .mon_data(mon_data),
        .mon_frame(mon_frame)
    );

    int n_chk = 0, n_bad = 0;
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // log of (frame,data) at every rising mon_clk edge
    int lf [0:4095];
    int ld [0:4095];
    int n_log = 0;
    int frame_hi_cnt = 0;
    logic p_clk = 0, p_fr = 0, p_dt = 0, p_rdy = 0;
    int since_rise = -1, hi_run = 0;
    int r1_bad = 0, r2_bad = 0, r7_bad = 0, r7_seen = 0, r1_seen = 0;
    bit mon_on = 0;

    always @(negedge clk) if (mon_on) begin
        if (mon_clk && !p_clk) begin
            if (n_log < 4096) begin lf[n_log] = int'(mon_frame); ld[n_log] = int'(mon_data); n_log++; end
            if (since_rise >= 0) begin r1_seen++; if (since_rise != DIV) r1_bad++; end
            since_rise = 0;
        end
        if (since_rise >= 0) since_rise++;
        if (!mon_clk && p_clk) begin if (hi_run != DIV/2) r1_bad++; end
        hi_run = mon_clk ? hi_run + 1 : 0;
        if ((mon_frame != p_fr || mon_data != p_dt) && !(p_clk && !mon_clk)) r2_bad++;
        if (p_rdy) begin r7_seen++; if (in_ready || mon_clk || !p_clk) r7_bad++; end
        if (mon_frame) frame_hi_cnt++;
        p_clk = mon_clk; p_fr = mon_frame; p_dt = mon_data; p_rdy = in_ready;
    end

    // expected packets
    int ep_len [0:31];
    int ep_tx  [0:31];
    int ep_ex  [0:31];
    int eb     [0:31][0:7];
    int n_pkt = 0;

    task automatic push(input logic [7:0] b, input bit f, input bit l, input bit t);
        in_valid = 1'b1; in_data = b; in_first = f; in_last = l; in_tx = t;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send(input int len, input int tx, input int exact, input int seed);
        ep_len[n_pkt] = len; ep_tx[n_pkt] = tx; ep_ex[n_pkt] = exact;
        for (int k = 0; k < len; k++) begin
            eb[n_pkt][k] = (seed * 37 + k * 91 + 5) & 255;
            if (seed >= 100) eb[n_pkt][k] = (k == 0) ? 8'h01 : (k == 1) ? 8'h80 : (k == 2) ? 8'hFF : 8'h00;
        end
        for (int k = 0; k < len; k++)
            push(8'(eb[n_pkt][k]), k == 0, k == len - 1, tx[0]);
        in_valid = 1'b0;
        n_pkt++;
    endtask

    task automatic idle_bits(input int n);
        repeat (n * DIV) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        int idx, gap, bad;
        repeat (3) @(negedge clk);
        // R10: during reset
        chk(!mon_clk && !mon_frame && !mon_data && !in_ready, "R10 in reset",
            int'({mon_clk, mon_frame, mon_data, in_ready}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mon_clk && !mon_frame && !mon_data && !in_ready, "R10 after reset",
            int'({mon_clk, mon_frame, mon_data, in_ready}), 0);
        mon_on = 1;

        // sweep length and direction, back to back (R3 R4 R5 R6)
        for (int len = 1; len <= 4; len++)
            for (int tx = 0; tx < 2; tx++)
                send(len, tx, (n_pkt == 0) ? 0 : 1, len * 2 + tx);
        send(4, 1, 1, 100);   // 01 80 FF 00 pattern
        idle_bits(12);

        // R9: underrun after first byte, no second byte offered
        ep_len[n_pkt] = 1; ep_tx[n_pkt] = 0; ep_ex[n_pkt] = 0; eb[n_pkt][0] = 8'hA5;
        push(8'hA5, 1'b1, 1'b0, 1'b0);
        in_valid = 1'b0;
        n_pkt++;
        idle_bits(20);

        // R8: byte without start flag while idle is dropped
        frame_hi_cnt = 0;
        push(8'h3C, 1'b0, 1'b1, 1'b1);
        in_valid = 1'b0;
        idle_bits(30);
        chk(frame_hi_cnt == 0, "R8 discarded byte keeps frame low", frame_hi_cnt, 0);

        send(2, 1, 0, 7);
        idle_bits(14);
        mon_on = 0;

        // parse the log against the expected packets
        idx = 0;
        for (int p = 0; p < n_pkt; p++) begin
            gap = 0;
            while (idx < n_log && lf[idx] == 0) begin gap++; idx++; end
            if (p > 0) begin
                if (ep_ex[p] != 0) chk(gap == IDB, "R6 gap exact", gap, IDB);
                else               chk(gap >= IDB, "R6 gap minimum", gap, IDB);
            end
            chk(idx < n_log && lf[idx] == 1 && ld[idx] == ep_tx[p], "R3 marker direction",
                (idx < n_log) ? ld[idx] : -1, ep_tx[p]);
            idx++;
            bad = 0;
            for (int k = 0; k < ep_len[p]; k++)
                for (int b = 0; b < 8; b++) begin
                    if (idx >= n_log || lf[idx] != 1 || ld[idx] != ((eb[p][k] >> b) & 1)) bad++;
                    idx++;
                end
            chk(bad == 0, (ep_ex[p] == 0 && p == 9) ? "R9 underrun payload" : "R4 payload LSB first", bad, 0);
            chk(idx < n_log && lf[idx] == 0 && ld[idx] == 0, "R5 frame and data drop",
                (idx < n_log) ? lf[idx] * 2 + ld[idx] : -1, 0);
        end
        while (idx < n_log && lf[idx] == 0) idx++;
        chk(idx == n_log, "R4 no extra framed bits", n_log - idx, 0);

        chk(r1_seen > 100 && r1_bad == 0, "R1 bit clock period and duty", r1_bad, 0);
        chk(r2_bad == 0, "R2 outputs move on falling edge", r2_bad, 0);
        chk(r7_seen > 20 && r7_bad == 0, "R7 ready single cycle before fall", r7_bad, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule